// File: doc/BRIEF.md
# Video Encryption Sequencing Controller

This block sequences link encryption for a single 24-bit video stream, one pixel per clock. It watches the data-enable, horizontal sync, vertical sync and frame-key control line together with an authenticated flag. A qualified pulse on the control line starts a frame-key computation in an external cipher. The block then applies that cipher's keystream to every active pixel of the frame. After every active line it runs a fixed-length rekey of the cipher.

The blank that follows a line is treated as unresolved until a horizontal or vertical sync says which kind of blank it is. The rekey starts at once, without waiting for that answer. A frame that opens without a fresh frame-key pulse drops the controller back to idle, and video then passes through in the clear. The block also keeps a frame index, which starts at one with the first encrypted frame, and it raises a strobe on every frame where the receiver's link-check response must be refreshed.

The cipher sits outside this block. It is driven through a start/done pair for the frame key, a stream enable that requests one keystream word per pixel, and a rekey enable.

Top module: `vid_crypt_seq`

## Requirements
- R1: After reset, or on the clock edge that follows any cycle with `auth_ok` low, `state_o` is Idle (0), `frame_idx` is 0 and `rekey_en` is low.
- R2: A qualified frame-key pulse moves the controller to FrameKey (1) when it is in Idle (0), UnknownBlank (3), HBlank (4) or VBlank (5) and `auth_ok` is high. On that same edge `fk_start` is high for exactly one cycle and `frame_idx` increments by one.
- R3: The `ctl3` input counts as a pulse only on its 8th consecutive high cycle. A pulse of 7 or fewer cycles has no effect.
- R4: In FrameKey, a rising `de` moves to Crypt (2) if `fk_done` has been seen since FrameKey was entered, or is high in that same cycle. Otherwise it moves to Idle (0) and the frame passes through in the clear.
- R5: In Crypt, a falling `de` moves to UnknownBlank (3). UnknownBlank goes to VBlank (5) on `vsync`, which takes priority, and otherwise to HBlank (4) on `hsync`. HBlank goes to VBlank on `vsync`, and back to Crypt on a rising `de`.
- R6: `rekey_en` is high for exactly 56 consecutive cycles. These begin in the cycle after `de` falls in Crypt, and the rekey continues through UnknownBlank and HBlank.
- R7: Every `de` cycle that is in Crypt, or that enters Crypt, is encrypted. In such a cycle `stream_en` is high and the registered output is red = pix_in[23:16]^ks_data[23:16], green = pix_in[15:8]^ks_data[15:8] and blue = pix_in[7:0]^ks_data[7:0].
- R8: In VBlank, a rising `de` with no qualified frame-key pulse returns the controller to Idle (0), and that pixel is not encrypted.
- R9: `resp_upd` is high for one cycle, on the edge where `frame_idx` becomes a nonzero multiple of 128, and at no other time.
- R10: `pix_out` is registered. In every cycle without encryption, `pix_out` equals `pix_in` from the previous cycle and `stream_en` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| auth_ok | input | 1 | Link is authenticated |
| de | input | 1 | Active-pixel data enable |
| hsync | input | 1 | Horizontal sync |
| vsync | input | 1 | Vertical sync |
| ctl3 | input | 1 | Frame-key request control line |
| pix_in | input | 24 | Input pixel, red in [23:16], green in [15:8], blue in [7:0] |
| ks_data | input | 24 | Keystream word from the cipher |
| fk_done | input | 1 | Cipher has finished the frame key |
| fk_start | output | 1 | One-cycle start of the frame-key computation |
| stream_en | output | 1 | Request one keystream word this cycle |
| rekey_en | output | 1 | Cipher rekey enable |
| pix_out | output | 24 | Registered output pixel |
| frame_idx | output | 16 | Index of the current encrypted frame |
| resp_upd | output | 1 | Link-check response update strobe |
| state_o | output | 3 | Controller state code |

## Verification
The assertions take three things for granted. Every horizontal blank lasts longer than the 56-cycle rekey. `de` never rises while a rekey is still running. `ctl3` is never high in the same cycle as a `de` edge in VBlank. The directed stimulus keeps every blank at 60 or more cycles and keeps the frame-key pulse apart from active video. It drops `auth_ok` only to bring the index back to zero, and the 56-cycle rekey check is made conditional on that flag.

// File: rtl/vid_crypt_seq.sv
module vid_crypt_seq #(
  parameter int PIX_W      = 24,
  parameter int IDX_W      = 16,
  parameter int CTL_MIN    = 8,
  parameter int REKEY_CLKS = 56,
  parameter int UPD_LOG2   = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             auth_ok,
  input  logic             de,
  input  logic             hsync,
  input  logic             vsync,
  input  logic             ctl3,
  input  logic [PIX_W-1:0] pix_in,
  input  logic [PIX_W-1:0] ks_data,
  input  logic             fk_done,
  output logic             fk_start,
  output logic             stream_en,
  output logic             rekey_en,
  output logic [PIX_W-1:0] pix_out,
  output logic [IDX_W-1:0] frame_idx,
  output logic             resp_upd,
  output logic [2:0]       state_o
);
  localparam int CW = $clog2(CTL_MIN + 1);
  localparam int RW = $clog2(REKEY_CLKS + 1);

  typedef enum logic [2:0] {
    S_IDLE = 3'd0, S_FKEY = 3'd1, S_CRYPT = 3'd2,
    S_UBLK = 3'd3, S_HBLK = 3'd4, S_VBLK = 3'd5
  } st_t;

  st_t st, nxt;
  logic [CW-1:0] ctl_cnt;
  logic [RW-1:0] rk_cnt;
  logic de_q, key_rdy;
  logic [IDX_W-1:0] idx_inc;

  wire de_rise  = de & ~de_q;
  wire de_fall  = ~de & de_q;
  wire ctl_hit  = ctl3 && (ctl_cnt == CW'(CTL_MIN - 1));
  wire fk_enter = (nxt == S_FKEY) && (st != S_FKEY);
  wire enc_px   = de && auth_ok && ((st == S_CRYPT) || (nxt == S_CRYPT));

  assign idx_inc   = frame_idx + 1'b1;
  assign stream_en = enc_px;
  assign rekey_en  = (rk_cnt != '0);
  assign state_o   = st;

  always_comb begin
    nxt = st;
    if (!auth_ok) nxt = S_IDLE;
    else case (st)
      S_IDLE:  if (ctl_hit) nxt = S_FKEY;
      S_FKEY:  if (de_rise) nxt = (key_rdy || fk_done) ? S_CRYPT : S_IDLE;
      S_CRYPT: if (de_fall) nxt = S_UBLK;
      S_UBLK: begin
        if (ctl_hit)    nxt = S_FKEY;
        else if (vsync) nxt = S_VBLK;
        else if (hsync) nxt = S_HBLK;
      end
      S_HBLK: begin
        if (ctl_hit)      nxt = S_FKEY;
        else if (vsync)   nxt = S_VBLK;
        else if (de_rise) nxt = S_CRYPT;
      end
      S_VBLK: begin
        if (ctl_hit)      nxt = S_FKEY;
        else if (de_rise) nxt = S_IDLE;
      end
      default: nxt = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      de_q      <= 1'b0;
      ctl_cnt   <= '0;
      key_rdy   <= 1'b0;
      rk_cnt    <= '0;
      frame_idx <= '0;
      resp_upd  <= 1'b0;
      fk_start  <= 1'b0;
      pix_out   <= '0;
    end else begin
      st       <= nxt;
      de_q     <= de;
      fk_start <= fk_enter;
      pix_out  <= enc_px ? (pix_in ^ ks_data) : pix_in;

      if (!ctl3)                        ctl_cnt <= '0;
      else if (ctl_cnt != CW'(CTL_MIN)) ctl_cnt <= ctl_cnt + 1'b1;

      if (fk_enter)                      key_rdy <= 1'b0;
      else if (st == S_FKEY && fk_done)  key_rdy <= 1'b1;

      if (!auth_ok)                    rk_cnt <= '0;
      else if (st == S_CRYPT && de_fall) rk_cnt <= RW'(REKEY_CLKS);
      else if (rk_cnt != '0)           rk_cnt <= rk_cnt - 1'b1;

      resp_upd <= 1'b0;
      if (!auth_ok) frame_idx <= '0;
      else if (fk_enter) begin
        frame_idx <= idx_inc;
        resp_upd  <= (idx_inc[UPD_LOG2-1:0] == '0);
      end
    end
  end
endmodule

// File: rtl/vid_crypt_seq_chk.sv
module vid_crypt_seq_chk #(
  parameter int PIX_W      = 24,
  parameter int IDX_W      = 16,
  parameter int REKEY_CLKS = 56,
  parameter int UPD_LOG2   = 7
) (
  input logic             clk,
  input logic             rst_n,
  input logic             auth_ok,
  input logic             de,
  input logic             ctl3,
  input logic [PIX_W-1:0] pix_in,
  input logic [PIX_W-1:0] ks_data,
  input logic             fk_start,
  input logic             stream_en,
  input logic             rekey_en,
  input logic [PIX_W-1:0] pix_out,
  input logic [IDX_W-1:0] frame_idx,
  input logic             resp_upd,
  input logic [2:0]       state_o
);
  logic [15:0] rk_seen;
  always_ff @(posedge clk) begin
    if (!rst_n)        rk_seen <= '0;
    else if (rekey_en) rk_seen <= rk_seen + 1'b1;
    else               rk_seen <= '0;
  end

  p_idle_noauth_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !auth_ok |=> (state_o == 3'd0 && frame_idx == '0 && !rekey_en));

  p_fkstart_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
    fk_start |-> (state_o == 3'd1) ##1 !fk_start);

  p_rekey_len_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(rekey_en) && $past(auth_ok)) |-> (rk_seen == 16'(REKEY_CLKS)));

  p_rekey_start_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rekey_en) |-> (state_o == 3'd3));

  p_xor_r7: assert property (@(posedge clk) disable iff (!rst_n)
    stream_en |=> (pix_out == $past(pix_in ^ ks_data)));

  p_vblank_de_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == 3'd5 && de && !ctl3) |=> (state_o == 3'd0));

  p_upd_mod_r9: assert property (@(posedge clk) disable iff (!rst_n)
    resp_upd |-> (frame_idx[UPD_LOG2-1:0] == '0 && frame_idx != '0));

  p_pass_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !stream_en |=> (pix_out == $past(pix_in)));
endmodule

bind vid_crypt_seq vid_crypt_seq_chk #(
  .PIX_W(PIX_W), .IDX_W(IDX_W), .REKEY_CLKS(REKEY_CLKS), .UPD_LOG2(UPD_LOG2)
) u_chk (
  .clk(clk), .rst_n(rst_n), .auth_ok(auth_ok), .de(de), .ctl3(ctl3),
  .pix_in(pix_in), .ks_data(ks_data), .fk_start(fk_start),
  .stream_en(stream_en), .rekey_en(rekey_en), .pix_out(pix_out),
  .frame_idx(frame_idx), .resp_upd(resp_upd), .state_o(state_o)
);

// File: tb/vid_crypt_seq_test.sv
`timescale 1ns/1ps
module vid_crypt_seq_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0, auth_ok = 1'b0, de = 1'b0, hsync = 1'b0, vsync = 1'b0;
  logic ctl3 = 1'b0, fk_done = 1'b0;
  logic [23:0] pix_in = '0, ks_data = '0;
  logic fk_start, stream_en, rekey_en, resp_upd;
  logic [23:0] pix_out;
  logic [15:0] frame_idx;
  logic [2:0] state_o;
  int checks = 0, fails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  vid_crypt_seq uut (
    .clk(clk), .rst_n(rst_n), .auth_ok(auth_ok), .de(de), .hsync(hsync),
    .vsync(vsync), .ctl3(ctl3), .pix_in(pix_in), .ks_data(ks_data),
    .fk_done(fk_done), .fk_start(fk_start), .stream_en(stream_en),
    .rekey_en(rekey_en), .pix_out(pix_out), .frame_idx(frame_idx),
    .resp_upd(resp_upd), .state_o(state_o));

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic qualify_ctl3(int n);
    for (int i = 0; i < n; i++) begin ctl3 = 1'b1; step(); end
  endtask

  // drives a line of n pixels; checks XOR or passthrough
  task automatic line(int n, bit enc, string req);
    for (int i = 0; i < n; i++) begin
      logic [23:0] p, k;
      p = 24'h10_20_30 + 24'(i * 24'h01_07_0b);
      k = 24'hA5_5A_C3 ^ 24'(i * 24'h03_11_05);
      de = 1'b1; pix_in = p; ks_data = k;
      #1 check({req, " stream_en"}, 32'(stream_en), 32'(enc));
      step();
      check({req, " pixel"}, 32'(pix_out), 32'(enc ? (p ^ k) : p));
    end
    de = 1'b0; pix_in = 24'h0f0f0f; ks_data = 24'hffffff;
  endtask

  task automatic test_reset();
    rst_n = 1'b0; auth_ok = 1'b0;
    repeat (3) step();
    check("R1 reset state", 32'(state_o), 0);
    check("R1 reset index", 32'(frame_idx), 0);
    check("R1 reset rekey", 32'(rekey_en), 0);
    rst_n = 1'b1; auth_ok = 1'b1;
    step();
  endtask

  task automatic test_short_ctl3();
    qualify_ctl3(7);
    ctl3 = 1'b0;
    check("R3 seven-cycle pulse ignored", 32'(state_o), 0);
    step();
    check("R3 no start", 32'(fk_start), 0);
    check("R3 index unchanged", 32'(frame_idx), 0);
  endtask

  task automatic test_frame_start();
    qualify_ctl3(7);
    check("R3 before eighth cycle", 32'(state_o), 0);
    qualify_ctl3(1);
    ctl3 = 1'b0;
    check("R2 enter FrameKey", 32'(state_o), 1);
    check("R2 fk_start", 32'(fk_start), 1);
    check("R2 index first frame", 32'(frame_idx), 1);
    step();
    check("R2 fk_start one cycle", 32'(fk_start), 0);
    fk_done = 1'b1; step(); fk_done = 1'b0;
    repeat (2) step();
    line(6, 1'b1, "R7 first line");
    check("R4 Crypt on de", 32'(state_o), 2);
  endtask

  task automatic test_blank_rekey();
    int highs = 0;
    step();
    check("R5 UnknownBlank after line", 32'(state_o), 3);
    check("R6 rekey starts", 32'(rekey_en), 1);
    highs = 1;
    for (int i = 0; i < 64; i++) begin
      hsync = (i >= 3 && i < 8);
      step();
      if (rekey_en) highs++;
      if (i == 3) check("R5 hsync to HBlank", 32'(state_o), 4);
    end
    hsync = 1'b0;
    check("R6 rekey length", 32'(highs), 56);
    check("R6 rekey ended", 32'(rekey_en), 0);
    line(4, 1'b1, "R7 second line");
    check("R5 HBlank to Crypt", 32'(state_o), 2);
  endtask

  task automatic test_vblank_missing_ctl3();
    step();
    vsync = 1'b1; hsync = 1'b1; step();
    check("R5 vsync priority to VBlank", 32'(state_o), 5);
    vsync = 1'b0; hsync = 1'b0;
    repeat (60) step();
    line(3, 1'b0, "R8 no frame key");
    check("R8 back to Idle", 32'(state_o), 0);
    line(3, 1'b0, "R10 idle passthrough");
  endtask

  task automatic test_no_done();
    step();
    qualify_ctl3(8); ctl3 = 1'b0;
    check("R2 from Idle again", 32'(state_o), 1);
    repeat (3) step();
    line(2, 1'b0, "R4 key not ready");
    check("R4 to Idle without done", 32'(state_o), 0);
  endtask

  task automatic test_auth_loss();
    step();
    qualify_ctl3(8); ctl3 = 1'b0;
    fk_done = 1'b1; step(); fk_done = 1'b0;
    line(3, 1'b1, "R7 before auth loss");
    auth_ok = 1'b0; de = 1'b1; step();
    check("R1 auth loss to Idle", 32'(state_o), 0);
    check("R1 auth loss index", 32'(frame_idx), 0);
    de = 1'b0; auth_ok = 1'b1; step();
  endtask

  task automatic test_update_strobe();
    int pulses = 0;
    logic [15:0] at_idx = '0;
    for (int f = 0; f < 130; f++) begin
      for (int i = 0; i < 8; i++) begin
        ctl3 = 1'b1; step();
        if (resp_upd) begin pulses++; at_idx = frame_idx; end
      end
      ctl3 = 1'b0;
      fk_done = 1'b1; step(); fk_done = 1'b0;
      if (resp_upd) pulses++;
      de = 1'b1; step(); step(); de = 1'b0; step();
      vsync = 1'b1; step(); vsync = 1'b0;
      repeat (60) begin step(); if (resp_upd) pulses++; end
    end
    check("R9 one strobe in 130 frames", 32'(pulses), 1);
    check("R9 strobe at frame 128", 32'(at_idx), 128);
    check("R9 index count", 32'(frame_idx), 130);
  endtask

  initial begin
    test_reset();
    test_short_ctl3();
    test_frame_start();
    test_blank_rekey();
    test_vblank_missing_ctl3();
    test_no_done();
    test_auth_loss();
    test_update_strobe();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule